// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block refills a translation buffer after a lookup misses. It takes a 32-bit virtual address and the physical base of the current page-table root, and performs a two-step walk through a page table held in memory. The virtual address is cut into a 10-bit first-level index, a 10-bit second-level index and a 12-bit page offset. The first read fetches a directory entry from the root table. The second read fetches the leaf entry from the table that the directory entry points to. Both reads use physical addresses, so the walk never needs translation itself.

A walk ends in one of two ways. It can hand back the leaf's physical page number and its permission and usage bits, ready to load into the buffer. It can also report a page fault that names the level where a non-present entry stopped it. The walker accepts one miss at a time. It talks to memory through a one-cycle request pulse and a response strobe that may come back after any number of cycles.

Every entry, at either level, uses this layout: bit 0 present, bit 1 readable, bit 2 writable, bit 3 dirty, bits 11..4 unused, bits 31..12 page number.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `walk_ready` is 1, and `mem_req_valid` and `done_valid` are 0.
- R2: A miss is accepted on a clock edge where `walk_valid` and `walk_ready` are both 1. In the next cycle `mem_req_valid` is 1 for exactly one cycle, with `mem_req_addr` = `root_base` + 4 × `walk_va[31:22]`.
- R3: After a first-level entry with bit 0 set arrives, a second one-cycle request is issued. Its address is {entry[31:12], 12'h000} + 4 × `walk_va[21:12]`.
- R4: A first-level entry with bit 0 clear ends the walk. `done_valid` and `done_fault` are 1 and `fault_level` is 0, and no second request is issued.
- R5: A second-level entry with bit 0 clear ends the walk with `done_fault` = 1 and `fault_level` = 1.
- R6: A second-level entry with bit 0 set ends the walk with `done_fault` = 0. `done_ppn` = entry[31:12], `done_read` = entry bit 1, `done_write` = entry bit 2 and `done_dirty` = entry bit 3.
- R7: While a walk is in progress `walk_ready` is 0, and `walk_valid` has no effect. The address used is the one presented at acceptance; later changes on `walk_va` or `root_base` do not alter the walk.
- R8: `done_valid` is high for exactly one cycle, and `walk_ready` is 1 in the following cycle.
- R9: A `mem_resp_valid` strobe that arrives while no read is outstanding is ignored: it starts no walk and produces no completion.
- R10: The walker waits any number of cycles for a response, and the result does not depend on that latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| walk_valid | input | 1 | A translation miss is offered |
| walk_ready | output | 1 | Walker is idle and will accept a miss |
| walk_va | input | 32 | Virtual address that missed |
| root_base | input | 32 | Physical base of the first-level table |
| mem_req_valid | output | 1 | One-cycle read request |
| mem_req_addr | output | 32 | Physical address of the entry to read |
| mem_resp_valid | input | 1 | Read data is valid |
| mem_resp_data | input | 32 | Entry returned by memory |
| done_valid | output | 1 | One-cycle completion strobe |
| done_fault | output | 1 | Completion is a page fault |
| fault_level | output | 1 | Level of the faulting entry, 0 first, 1 second |
| done_ppn | output | 20 | Physical page number of the leaf |
| done_read | output | 1 | Leaf readable bit |
| done_write | output | 1 | Leaf writable bit |
| done_dirty | output | 1 | Leaf dirty bit |

## Verification
The hardest case to reach from the ports is a walk that stays busy while its inputs change under it. That means a second miss arriving and the virtual address being replaced while a read is outstanding, under a slow memory. The bench's memory model answers after a programmed latency. During that wait the bench holds `walk_valid` high and drives an inverted address. It then checks that only the two original reads were issued and that the result matches the first miss. Stray response strobes are driven while the walker is idle, to show they are ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int VA_W      = 32;
    localparam int PA_W      = 32;
    localparam int IDX_W     = 10;
    localparam int OFF_W     = 12;
    localparam int PTE_W     = 32;
    localparam int PPN_W     = PA_W - OFF_W;
    localparam int PTE_SHIFT = 2;
    localparam int SPARE_W   = OFF_W - 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE, ST_FAULT
    } walk_state_e;

    typedef struct packed {
        logic [PPN_W-1:0]   ppn;
        logic [SPARE_W-1:0] spare;
        logic               dirty;
        logic               writable;
        logic               readable;
        logic               present;
    } pte_t;

    function automatic pte_t to_pte(input logic [PTE_W-1:0] word);
        return pte_t'(word);
    endfunction

    function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] base,
                                                   input logic [IDX_W-1:0] idx);
        logic [PA_W-1:0] wide_idx;
        wide_idx = {{(PA_W-IDX_W){1'b0}}, idx};
        return base + (wide_idx << PTE_SHIFT);
    endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
#(
    parameter int VA_BITS  = VA_W,
    parameter int PA_BITS  = PA_W,
    parameter int IX_BITS  = IDX_W,
    parameter int OFS_BITS = OFF_W
) (
    input  logic [VA_BITS-1:0]          va,
    input  logic [PA_BITS-1:0]          root,
    input  logic [PA_BITS-OFS_BITS-1:0] dir_ppn,
    input  logic                        second,
    output logic [PA_BITS-1:0]          addr
);
    localparam int HI_LSB = OFS_BITS + IX_BITS;

    logic [IX_BITS-1:0] idx_hi, idx_lo;
    logic [PA_BITS-1:0] dir_base;

    always_comb begin
        idx_hi   = va[HI_LSB +: IX_BITS];
        idx_lo   = va[OFS_BITS +: IX_BITS];
        dir_base = {dir_ppn, {OFS_BITS{1'b0}}};
        addr     = second ? entry_addr(dir_base, idx_lo) : entry_addr(root, idx_hi);
    end
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        walk_valid,
    input  logic        resp_valid,
    input  logic        resp_present,
    output walk_state_e state,
    output logic        accept,
    output logic        dir_load,
    output logic        leaf_load,
    output logic        fault_load
);
    walk_state_e nxt;

    always_comb begin
        nxt        = state;
        accept     = 1'b0;
        dir_load   = 1'b0;
        leaf_load  = 1'b0;
        fault_load = 1'b0;
        unique case (state)
            ST_IDLE: if (walk_valid) begin
                accept = 1'b1;
                nxt    = ST_L1_REQ;
            end
            ST_L1_REQ:  nxt = ST_L1_WAIT;
            ST_L1_WAIT: if (resp_valid) begin
                if (resp_present) begin
                    dir_load = 1'b1;
                    nxt      = ST_L2_REQ;
                end else begin
                    fault_load = 1'b1;
                    nxt        = ST_FAULT;
                end
            end
            ST_L2_REQ:  nxt = ST_L2_WAIT;
            ST_L2_WAIT: if (resp_valid) begin
                if (resp_present) begin
                    leaf_load = 1'b1;
                    nxt       = ST_DONE;
                end else begin
                    fault_load = 1'b1;
                    nxt        = ST_FAULT;
                end
            end
            ST_DONE, ST_FAULT: nxt = ST_IDLE;
            default:           nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             walk_valid,
    output logic             walk_ready,
    input  logic [VA_W-1:0]  walk_va,
    input  logic [PA_W-1:0]  root_base,
    output logic             mem_req_valid,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_resp_valid,
    input  logic [PTE_W-1:0] mem_resp_data,
    output logic             done_valid,
    output logic             done_fault,
    output logic             fault_level,
    output logic [PPN_W-1:0] done_ppn,
    output logic             done_read,
    output logic             done_write,
    output logic             done_dirty
);
    walk_state_e      state;
    logic             accept, dir_load, leaf_load, fault_load;
    logic [VA_W-1:0]  va_q;
    logic [PA_W-1:0]  root_q;
    logic [PPN_W-1:0] dir_ppn_q;
    pte_t             resp_pte, leaf_q;
    logic             level_q;

    assign resp_pte = to_pte(mem_resp_data);

    ptw_ctrl i_ctrl (
        .clk          (clk),
        .rst          (rst),
        .walk_valid   (walk_valid),
        .resp_valid   (mem_resp_valid),
        .resp_present (resp_pte.present),
        .state        (state),
        .accept       (accept),
        .dir_load     (dir_load),
        .leaf_load    (leaf_load),
        .fault_load   (fault_load)
    );

    ptw_addr_gen i_addr (
        .va      (va_q),
        .root    (root_q),
        .dir_ppn (dir_ppn_q),
        .second  (state == ST_L2_REQ),
        .addr    (mem_req_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q      <= '0;
            root_q    <= '0;
            dir_ppn_q <= '0;
            leaf_q    <= '0;
            level_q   <= 1'b0;
        end else begin
            if (accept) begin
                va_q   <= walk_va;
                root_q <= root_base;
            end
            if (dir_load)   dir_ppn_q <= resp_pte.ppn;
            if (leaf_load)  leaf_q    <= resp_pte;
            if (fault_load) level_q   <= (state == ST_L2_WAIT);
        end
    end

    assign walk_ready    = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
    assign done_valid    = (state == ST_DONE) || (state == ST_FAULT);
    assign done_fault    = (state == ST_FAULT);
    assign fault_level   = level_q;
    assign done_ppn      = leaf_q.ppn;
    assign done_read     = leaf_q.readable;
    assign done_write    = leaf_q.writable;
    assign done_dirty    = leaf_q.dirty;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
    input logic clk,
    input logic rst,
    input logic walk_valid,
    input logic walk_ready,
    input logic mem_req_valid,
    input logic done_valid,
    input logic done_fault,
    input logic fault_level
);
    logic [1:0] req_cnt;

    always_ff @(posedge clk) begin
        if (rst)                           req_cnt <= '0;
        else if (walk_valid && walk_ready) req_cnt <= '0;
        else if (mem_req_valid && req_cnt != 2'd3) req_cnt <= req_cnt + 2'd1;
    end

    // R2
    accept_issues_read_chk: assert property (@(posedge clk) disable iff (rst)
        (walk_valid && walk_ready) |=> (mem_req_valid && !walk_ready));
    // R2
    req_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |=> !mem_req_valid);
    // R6
    success_two_reads_chk: assert property (@(posedge clk) disable iff (rst)
        (done_valid && !done_fault) |-> (req_cnt == 2'd2));
    // R4
    dir_fault_one_read_chk: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_fault && !fault_level) |-> (req_cnt == 2'd1));
    // R5
    leaf_fault_two_reads_chk: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_fault && fault_level) |-> (req_cnt == 2'd2));
    // R8
    done_then_ready_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> (walk_ready && !done_valid));
    // R7
    busy_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({walk_ready, mem_req_valid, done_valid}));
endmodule

bind ptw_walker ptw_walker_chk i_chk (
    .clk           (clk),
    .rst           (rst),
    .walk_valid    (walk_valid),
    .walk_ready    (walk_ready),
    .mem_req_valid (mem_req_valid),
    .done_valid    (done_valid),
    .done_fault    (done_fault),
    .fault_level   (fault_level)
);

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        walk_valid = 1'b0;
    logic        walk_ready;
    logic [31:0] walk_va = '0;
    logic [31:0] root_base = '0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_resp_valid = 1'b0;
    logic [31:0] mem_resp_data = '0;
    logic        done_valid, done_fault, fault_level;
    logic [19:0] done_ppn;
    logic        done_read, done_write, done_dirty;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [31:0] mem_a [8];
    logic [31:0] mem_d [8];
    int          mem_n = 0;
    int          lat = 0;
    bit          pending = 0;
    int          cnt = 0;
    logic [31:0] pend_addr = '0;
    logic [31:0] req_log [4];
    int          req_n = 0;
    bit          stray = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_walker i_ptw_walker (.*);

    function automatic logic [31:0] lookup(input logic [31:0] a);
        for (int i = 0; i < mem_n; i++) if (mem_a[i] == a) return mem_d[i];
        return 32'h0;
    endfunction

    always @(negedge clk) begin
        mem_resp_valid = 1'b0;
        if (stray) begin
            mem_resp_valid = 1'b1;
            mem_resp_data  = 32'hFFFF_F00F;
        end
        if (pending) begin
            if (cnt == 0) begin
                mem_resp_valid = 1'b1;
                mem_resp_data  = lookup(pend_addr);
                pending = 0;
            end else cnt--;
        end
        if (mem_req_valid) begin
            pending   = 1;
            cnt       = lat;
            pend_addr = mem_req_addr;
            if (req_n < 4) req_log[req_n] = mem_req_addr;
            req_n++;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [31:0] a, input logic [31:0] d);
        mem_a[mem_n] = a;
        mem_d[mem_n] = d;
        mem_n++;
    endtask

    task automatic run_walk(input logic [31:0] va, input logic [31:0] root,
                            input int latency, input bit poke);
        bit seen = 0;
        lat   = latency;
        req_n = 0;
        @(negedge clk);
        walk_va = va; root_base = root; walk_valid = 1'b1;
        @(negedge clk);
        walk_valid = 1'b0;
        walk_va    = ~va;
        root_base  = ~root;
        for (int k = 0; k < 300 && !seen; k++) begin
            if (done_valid) begin
                seen = 1;
                walk_valid = 1'b0;
            end else begin
                if (poke) begin
                    walk_valid = 1'b1;
                    check("R7 busy not ready", {31'b0, walk_ready}, 32'd0);
                end
                @(negedge clk);
            end
        end
        if (!seen) begin
            failures++;
            $display("FAIL R10 walk timed out actual=none expected=done");
        end
    endtask

    task automatic after_done;
        @(negedge clk);
        check("R8 done one cycle", {31'b0, done_valid}, 32'd0);
        check("R8 ready after done", {31'b0, walk_ready}, 32'd1);
    endtask

    task automatic t_reset;
        check("R1 ready", {31'b0, walk_ready}, 32'd1);
        check("R1 no req", {31'b0, mem_req_valid}, 32'd0);
        check("R1 no done", {31'b0, done_valid}, 32'd0);
    endtask

    task automatic t_success_fast;
        mem_n = 0;
        put(32'h0001_0004, 32'h0002_0001);
        put(32'h0002_000C, 32'hABCD_E00F);
        run_walk(32'h0040_3123, 32'h0001_0000, 0, 0);
        check("R2 dir addr", req_log[0], 32'h0001_0004);
        check("R3 leaf addr", req_log[1], 32'h0002_000C);
        check("R6 no fault", {31'b0, done_fault}, 32'd0);
        check("R6 ppn", {12'b0, done_ppn}, 32'h000A_BCDE);
        check("R6 flags", {29'b0, done_dirty, done_write, done_read}, 32'd7);
        after_done();
        check("R6 two reads", req_n, 2);
    endtask

    task automatic t_success_slow;
        mem_n = 0;
        put(32'h0008_0FFC, 32'h0003_0001);
        put(32'h0003_0008, 32'h1234_5003);
        run_walk(32'hFFC0_2FFF, 32'h0008_0000, 5, 0);
        check("R10 dir addr", req_log[0], 32'h0008_0FFC);
        check("R10 leaf addr", req_log[1], 32'h0003_0008);
        check("R10 ppn", {12'b0, done_ppn}, 32'h0001_2345);
        check("R6 read only", {29'b0, done_dirty, done_write, done_read}, 32'd1);
        check("R10 no fault", {31'b0, done_fault}, 32'd0);
        after_done();
    endtask

    task automatic t_dir_fault;
        mem_n = 0;
        run_walk(32'h0080_0000, 32'h0001_0000, 2, 0);
        check("R4 dir addr", req_log[0], 32'h0001_0008);
        check("R4 fault", {31'b0, done_fault}, 32'd1);
        check("R4 level", {31'b0, fault_level}, 32'd0);
        after_done();
        check("R4 one read", req_n, 1);
    endtask

    task automatic t_leaf_fault;
        mem_n = 0;
        put(32'h0001_0004, 32'h0002_0001);
        put(32'h0002_0014, 32'h0009_900E);
        run_walk(32'h0040_5000, 32'h0001_0000, 1, 0);
        check("R5 leaf addr", req_log[1], 32'h0002_0014);
        check("R5 fault", {31'b0, done_fault}, 32'd1);
        check("R5 level", {31'b0, fault_level}, 32'd1);
        after_done();
        check("R5 two reads", req_n, 2);
    endtask

    task automatic t_busy;
        mem_n = 0;
        put(32'h0001_0004, 32'h0002_0001);
        put(32'h0002_000C, 32'hABCD_E00F);
        run_walk(32'h0040_3123, 32'h0001_0000, 3, 1);
        check("R7 dir addr kept", req_log[0], 32'h0001_0004);
        check("R7 leaf addr kept", req_log[1], 32'h0002_000C);
        check("R7 ppn kept", {12'b0, done_ppn}, 32'h000A_BCDE);
        after_done();
        repeat (2) @(negedge clk);
        check("R7 no extra reads", req_n, 2);
    endtask

    task automatic t_stray;
        req_n = 0;
        @(negedge clk);
        stray = 1;
        @(negedge clk);
        stray = 0;
        @(negedge clk);
        check("R9 still ready", {31'b0, walk_ready}, 32'd1);
        check("R9 no done", {31'b0, done_valid}, 32'd0);
        check("R9 no read", req_n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_success_fast();
        t_success_slow();
        t_dir_fault();
        t_leaf_fault();
        t_busy();
        t_stray();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end
endmodule